// File: doc/BRIEF.md
# Chained Converter Readout Sequencer

This block is the host-side controller for a string of 18-bit successive-approximation converters that share one serial bus in daisy-chain fashion. It raises the convert strobe, waits for the conversions to finish, and then drives a burst of serial clock pulses. The burst is long enough to pull the results of every device in the chain through the nearest device's output. The captured frame is then cut into 18-bit two's-complement words. Each word goes out on a valid/ready stream together with the position of its device in the chain.

There are two ways to detect the end of conversion, and a parameter picks one. In timed mode the controller counts a fixed number of clock cycles after the strobe rises. In flag mode it waits for the data line to rise. That rise is the busy indicator, and the flag bit that comes with it is dropped from the frame. A level-sensitive start request launches one acquisition. A new strobe is held back until several conditions all hold: a minimum period has passed since the previous strobe, the strobe has been low for a minimum acquisition window, and every word of the previous frame has been accepted.

Top module: `adc_chain_host`

## Requirements
- R1: While reset is asserted, the convert strobe, the serial clock and the word valid output are all low.
- R2: When the block is idle and its timing limits are met, start_i high at a clock edge raises cnv_o in the cycle after that edge. While start_i stays low, no conversion is launched.
- R3: Two rising edges of cnv_o are always at least MIN_PERIOD clock cycles apart.
- R4: Before each rising edge, cnv_o has been low for at least ACQ_MIN clock cycles, counted from its last falling edge.
- R5: In timed mode (USE_BUSY = 0), the serial clock first goes high no earlier than CONV_WAIT cycles after cnv_o rises.
- R6: In flag mode (USE_BUSY = 1), the burst starts when sdata_i rises while a conversion is pending. The burst has N_DEV*BITS+1 falling edges, and the bit taken at the first falling edge is discarded.
- R7: sck_o idles low and is high only while cnv_o is high. Each period is 2*SCK_DIV cycles. sdata_i is sampled at each falling edge. In timed mode a burst has exactly N_DEV*BITS falling edges, and cnv_o falls once the burst ends.
- R8: The frame is taken MSB first. The first BITS bits sampled form word index 0, the next BITS bits form index 1, and so on up to N_DEV-1. Each word is passed through unchanged, with its sign bit in bit BITS-1.
- R9: While word_valid_o is high and word_ready_i is low, word_valid_o, word_data_o and word_idx_o all hold their values into the next cycle.
- R10: cnv_o does not rise again until all N_DEV words of the previous frame have been accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Level request to launch an acquisition |
| cnv_o | output | 1 | Convert strobe, held high through readout |
| sck_o | output | 1 | Serial clock to the chain |
| sdata_i | input | 1 | Serial data from the device nearest the host |
| word_valid_o | output | 1 | Output word available |
| word_ready_i | input | 1 | Consumer accepts the word |
| word_data_o | output | BITS | Two's-complement result |
| word_idx_o | output | IDX_W | Chain position of the word, 0 = nearest device |

## Verification
Two events can land in the same cycle: the last word of a frame being accepted, and the pacer releasing the next strobe. To provoke this, start_i is held high continuously while word_ready_i is randomly dropped. How the two events line up then changes from frame to frame. Three things are checked at every strobe rise: the number of words accepted must already equal N_DEV times the number of earlier strobes, and both the period window and the acquisition window must be met. One instance uses settings where the period window is the limit and the other uses settings where the acquisition window is the limit, so each check is exercised in its binding case.

// File: rtl/adc_chain_pkg.sv
package adc_chain_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CONV  = 2'd1,
      ST_SHIFT = 2'd2,
      ST_EMIT  = 2'd3
   } seq_state_t;

   // Width of a counter that must hold values 0..maxv
   function automatic int cnt_w(input int maxv);
      return (maxv < 2) ? 1 : $clog2(maxv + 1);
   endfunction

endpackage

// File: rtl/adc_chain_pacer.sv
module adc_chain_pacer
   import adc_chain_pkg::*;
#(
   parameter int MIN_PERIOD = 250,
   parameter int ACQ_MIN    = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch_i,
   input  logic drop_i,
   output logic clear_o
);

   localparam int RW = cnt_w(MIN_PERIOD);
   localparam int AW = cnt_w(ACQ_MIN);

   logic [RW-1:0] rise_cnt;
   logic [AW-1:0] low_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rise_cnt <= RW'(MIN_PERIOD);
         low_cnt  <= AW'(ACQ_MIN);
      end else begin
         if (launch_i)
            rise_cnt <= RW'(1);
         else if (rise_cnt < RW'(MIN_PERIOD))
            rise_cnt <= rise_cnt + RW'(1);

         if (drop_i)
            low_cnt <= AW'(1);
         else if (low_cnt < AW'(ACQ_MIN))
            low_cnt <= low_cnt + AW'(1);
      end
   end

   assign clear_o = (rise_cnt >= RW'(MIN_PERIOD)) && (low_cnt >= AW'(ACQ_MIN));

endmodule

// File: rtl/adc_chain_shifter.sv
module adc_chain_shifter
   import adc_chain_pkg::*;
#(
   parameter int TOTAL   = 54,
   parameter int FALLS   = 54,
   parameter int SCK_DIV = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             sdata_i,
   output logic             sck_o,
   output logic             done_o,
   output logic [TOTAL-1:0] frame_o
);

   localparam int DW = cnt_w(SCK_DIV - 1);
   localparam int FW = cnt_w(FALLS - 1);

   logic          active;
   logic [DW-1:0] div_cnt;
   logic [FW-1:0] fall_cnt;
   logic          sck_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active   <= 1'b0;
         div_cnt  <= '0;
         fall_cnt <= '0;
         sck_q    <= 1'b0;
         done_o   <= 1'b0;
         frame_o  <= '0;
      end else begin
         done_o <= 1'b0;
         if (run_i) begin
            active   <= 1'b1;
            div_cnt  <= '0;
            fall_cnt <= '0;
            sck_q    <= 1'b0;
         end else if (active) begin
            if (div_cnt == DW'(SCK_DIV - 1)) begin
               div_cnt <= '0;
               sck_q   <= ~sck_q;
               if (sck_q) begin
                  frame_o <= {frame_o[TOTAL-2:0], sdata_i};
                  if (fall_cnt == FW'(FALLS - 1)) begin
                     active <= 1'b0;
                     done_o <= 1'b1;
                  end else begin
                     fall_cnt <= fall_cnt + FW'(1);
                  end
               end
            end else begin
               div_cnt <= div_cnt + DW'(1);
            end
         end
      end
   end

   assign sck_o = sck_q;

endmodule

// File: rtl/adc_chain_emitter.sv
module adc_chain_emitter #(
   parameter int N_DEV = 3,
   parameter int BITS  = 18,
   parameter int IDX_W = 2,
   localparam int TOTAL = N_DEV * BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [TOTAL-1:0] frame_i,
   output logic             valid_o,
   input  logic             ready_i,
   output logic [BITS-1:0]  data_o,
   output logic [IDX_W-1:0] idx_o
);

   logic [TOTAL-1:0] word_sr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_sr <= '0;
         idx_o   <= '0;
         valid_o <= 1'b0;
      end else if (load_i) begin
         word_sr <= frame_i;
         idx_o   <= '0;
         valid_o <= 1'b1;
      end else if (valid_o && ready_i) begin
         if (idx_o == IDX_W'(N_DEV - 1)) begin
            valid_o <= 1'b0;
         end else begin
            idx_o   <= idx_o + IDX_W'(1);
            word_sr <= word_sr << BITS;
         end
      end
   end

   assign data_o = word_sr[TOTAL-1 -: BITS];

endmodule

// File: rtl/adc_chain_host.sv
module adc_chain_host
   import adc_chain_pkg::*;
#(
   parameter int N_DEV      = 3,
   parameter int BITS       = 18,
   parameter int SCK_DIV    = 2,
   parameter int CONV_WAIT  = 210,
   parameter int MIN_PERIOD = 250,
   parameter int ACQ_MIN    = 40,
   parameter int USE_BUSY   = 0,
   localparam int IDX_W     = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   output logic             cnv_o,
   output logic             sck_o,
   input  logic             sdata_i,
   output logic             word_valid_o,
   input  logic             word_ready_i,
   output logic [BITS-1:0]  word_data_o,
   output logic [IDX_W-1:0] word_idx_o
);

   localparam int TOTAL = N_DEV * BITS;
   localparam int FALLS = TOTAL + ((USE_BUSY != 0) ? 1 : 0);

   if (N_DEV < 1)      begin : g_bad_ndev  $error("N_DEV must be at least 1");     end
   if (BITS < 2)       begin : g_bad_bits  $error("BITS must be at least 2");      end
   if (SCK_DIV < 1)    begin : g_bad_div   $error("SCK_DIV must be at least 1");   end
   if (CONV_WAIT < 1)  begin : g_bad_wait  $error("CONV_WAIT must be at least 1"); end
   if (MIN_PERIOD < 1) begin : g_bad_per   $error("MIN_PERIOD must be at least 1"); end
   if (ACQ_MIN < 1)    begin : g_bad_acq   $error("ACQ_MIN must be at least 1");   end
   if (USE_BUSY != 0 && USE_BUSY != 1) begin : g_bad_mode
      $error("USE_BUSY must be 0 or 1");
   end

   seq_state_t       st;
   logic             cnv_q;
   logic             clear;
   logic             launch;
   logic             conv_end;
   logic             drop;
   logic             shift_done;
   logic [TOTAL-1:0] frame;

   assign launch = (st == ST_IDLE) && start_i && clear;
   assign drop   = (st == ST_SHIFT) && shift_done;

   // End-of-conversion detection variant
   if (USE_BUSY != 0) begin : g_busy
      logic sd_q;
      always_ff @(posedge clk) begin
         if (!rst_n) sd_q <= 1'b0;
         else        sd_q <= sdata_i;
      end
      assign conv_end = (st == ST_CONV) && sdata_i && !sd_q;
   end else begin : g_wait
      localparam int WW = cnt_w(CONV_WAIT);
      logic [WW-1:0] wait_cnt;
      always_ff @(posedge clk) begin
         if (!rst_n)
            wait_cnt <= '0;
         else if (launch)
            wait_cnt <= '0;
         else if (st == ST_CONV && !conv_end)
            wait_cnt <= wait_cnt + WW'(1);
      end
      assign conv_end = (st == ST_CONV) && (wait_cnt == WW'(CONV_WAIT - 1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         cnv_q <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE:  if (launch)        begin st <= ST_CONV;  cnv_q <= 1'b1; end
            ST_CONV:  if (conv_end)      st <= ST_SHIFT;
            ST_SHIFT: if (shift_done)    begin st <= ST_EMIT;  cnv_q <= 1'b0; end
            ST_EMIT:  if (!word_valid_o) st <= ST_IDLE;
            default:  st <= ST_IDLE;
         endcase
      end
   end

   assign cnv_o = cnv_q;

   adc_chain_pacer #(
      .MIN_PERIOD (MIN_PERIOD),
      .ACQ_MIN    (ACQ_MIN)
   ) u_pacer (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch_i (launch),
      .drop_i   (drop),
      .clear_o  (clear)
   );

   adc_chain_shifter #(
      .TOTAL   (TOTAL),
      .FALLS   (FALLS),
      .SCK_DIV (SCK_DIV)
   ) u_shifter (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (conv_end),
      .sdata_i (sdata_i),
      .sck_o   (sck_o),
      .done_o  (shift_done),
      .frame_o (frame)
   );

   adc_chain_emitter #(
      .N_DEV (N_DEV),
      .BITS  (BITS),
      .IDX_W (IDX_W)
   ) u_emitter (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (drop),
      .frame_i (frame),
      .valid_o (word_valid_o),
      .ready_i (word_ready_i),
      .data_o  (word_data_o),
      .idx_o   (word_idx_o)
   );

endmodule

// File: rtl/adc_chain_host_chk.sv
module adc_chain_host_chk
   import adc_chain_pkg::*;
#(
   parameter int N_DEV      = 3,
   parameter int BITS       = 18,
   parameter int CONV_WAIT  = 210,
   parameter int MIN_PERIOD = 250,
   parameter int ACQ_MIN    = 40,
   parameter int USE_BUSY   = 0,
   parameter int IDX_W      = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnv_o,
   input logic             sck_o,
   input logic             word_valid_o,
   input logic             word_ready_i,
   input logic [BITS-1:0]  word_data_o,
   input logic [IDX_W-1:0] word_idx_o
);

   localparam int RCAP = MIN_PERIOD + CONV_WAIT + 1;
   localparam int RW   = cnt_w(RCAP);
   localparam int AW   = cnt_w(ACQ_MIN);

   logic          cnv_d;
   logic [RW-1:0] rise_gap;
   logic [AW-1:0] low_run;
   logic          cnv_up;

   assign cnv_up = cnv_o && !cnv_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnv_d    <= 1'b0;
         rise_gap <= RW'(RCAP);
         low_run  <= AW'(ACQ_MIN);
      end else begin
         cnv_d <= cnv_o;
         if (cnv_up)
            rise_gap <= RW'(1);
         else if (rise_gap < RW'(RCAP))
            rise_gap <= rise_gap + RW'(1);
         if (!cnv_o && cnv_d)
            low_run <= AW'(1);
         else if (low_run < AW'(ACQ_MIN))
            low_run <= low_run + AW'(1);
      end
   end

   a_r3_min_period: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_up |-> rise_gap >= RW'(MIN_PERIOD));

   a_r4_acq_window: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_up |-> low_run >= AW'(ACQ_MIN));

   a_r7_sck_inside_cnv: assert property (@(posedge clk) disable iff (!rst_n)
      sck_o |-> cnv_o);

   a_r8_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid_o |-> word_idx_o <= IDX_W'(N_DEV - 1));

   a_r9_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid_o && !word_ready_i) |=>
         (word_valid_o && $stable(word_data_o) && $stable(word_idx_o)));

   a_r10_no_launch_pending: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_up |-> !word_valid_o);

   if (USE_BUSY == 0) begin : g_wait_chk
      a_r5_conv_wait: assert property (@(posedge clk) disable iff (!rst_n)
         sck_o |-> rise_gap >= RW'(CONV_WAIT));
   end

endmodule

bind adc_chain_host adc_chain_host_chk #(
   .N_DEV      (N_DEV),
   .BITS       (BITS),
   .CONV_WAIT  (CONV_WAIT),
   .MIN_PERIOD (MIN_PERIOD),
   .ACQ_MIN    (ACQ_MIN),
   .USE_BUSY   (USE_BUSY),
   .IDX_W      (IDX_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cnv_o        (cnv_o),
   .sck_o        (sck_o),
   .word_valid_o (word_valid_o),
   .word_ready_i (word_ready_i),
   .word_data_o  (word_data_o),
   .word_idx_o   (word_idx_o)
);

// File: tb/adc_chain_host_bench.sv
// Behavioural chain of converters: shifts on observed sck falling edges.
module adc_chain_bench_conv #(
   parameter int TOT    = 54,
   parameter int BUSY   = 0,
   parameter int CONV_T = 14
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cnv,
   input  logic           sck,
   input  logic [TOT-1:0] data_i,
   output logic           sdo,
   output logic [TOT-1:0] held_o
);
   logic           cnv_p, sck_p, done, lead;
   logic [TOT-1:0] sreg;
   int             tmr, delay;

   always @(negedge clk) begin
      if (!rst_n) begin
         cnv_p <= 1'b0; sck_p <= 1'b0; done <= 1'b1; lead <= 1'b0;
         sreg <= '0; held_o <= '0; tmr <= 0; delay <= CONV_T;
      end else begin
         if (cnv && !cnv_p) begin
            done  <= 1'b0;
            lead  <= 1'b0;
            tmr   <= 0;
            delay <= (BUSY != 0) ? 3 + int'($urandom % 30) : CONV_T;
         end else if (cnv && !done) begin
            tmr <= tmr + 1;
            if (tmr + 1 >= delay) begin
               done   <= 1'b1;
               sreg   <= data_i;
               held_o <= data_i;
               lead   <= (BUSY != 0);
            end
         end
         if (sck_p && !sck && done) begin
            if (lead) lead <= 1'b0;
            else      sreg <= {sreg[TOT-2:0], 1'b0};
         end
         cnv_p <= cnv;
         sck_p <= sck;
      end
   end

   // Before conversion end: busy line low in flag mode, junk ones otherwise
   assign sdo = !done ? (BUSY == 0) : (lead ? 1'b1 : sreg[TOT-1]);
endmodule

module adc_chain_host_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NDEV = 3;
   localparam int BITS = 18;
   localparam int TOT  = NDEV * BITS;
   localparam int ITER = 25;
   localparam int CW0 = 16, MINP0 = 400, ACQ0 = 8,   DIV0 = 2;
   localparam int CW1 = 5,  MINP1 = 20,  ACQ1 = 150, DIV1 = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] start_q = '0;
   logic [1:0] ready_q = '0;
   logic [1:0] cnv, sck, sdata, valid;
   logic [BITS-1:0] wdata [2];
   logic [1:0]      widx  [2];
   logic [TOT-1:0]  data_q [2];
   logic [TOT-1:0]  held   [2];

   int nchk = 0, nfail = 0, cyc = 0;
   int got [2], nrise [2], nfall [2], t_rise [2], t_fall [2], falls [2];
   bit sck_first [2], stall_p [2];
   logic [1:0] cnv_p = '0, sck_p = '0;
   logic [BITS-1:0] data_p [2];
   logic [1:0]      idx_p  [2];

   always #(CLK_PERIOD / 2) clk = ~clk;

   for (genvar g = 0; g < 2; g++) begin : g_dut
      adc_chain_host #(
         .N_DEV (NDEV), .BITS (BITS),
         .SCK_DIV    (g == 0 ? DIV0 : DIV1),
         .CONV_WAIT  (g == 0 ? CW0 : CW1),
         .MIN_PERIOD (g == 0 ? MINP0 : MINP1),
         .ACQ_MIN    (g == 0 ? ACQ0 : ACQ1),
         .USE_BUSY   (g)
      ) u_adc_chain_host (
         .clk (clk), .rst_n (rst_n), .start_i (start_q[g]),
         .cnv_o (cnv[g]), .sck_o (sck[g]), .sdata_i (sdata[g]),
         .word_valid_o (valid[g]), .word_ready_i (ready_q[g]),
         .word_data_o (wdata[g]), .word_idx_o (widx[g])
      );
      adc_chain_bench_conv #(.TOT (TOT), .BUSY (g), .CONV_T (CW0 - 2)) u_conv (
         .clk (clk), .rst_n (rst_n), .cnv (cnv[g]), .sck (sck[g]),
         .data_i (data_q[g]), .sdo (sdata[g]), .held_o (held[g])
      );
   end

   function automatic logic [BITS-1:0] exp_word(input logic [TOT-1:0] fr, input int k);
      return fr[TOT-1-BITS*k -: BITS];
   endfunction

   function automatic logic [TOT-1:0] pattern(input int it);
      logic [TOT-1:0] p;
      p = '0;
      for (int k = 0; k < NDEV; k++) begin
         logic [BITS-1:0] w;
         case (it)
            0: w = 18'h20000;
            1: w = 18'h1FFFF;
            2: w = 18'h00000;
            3: w = (k % 2 == 0) ? 18'h2AAAA : 18'h15555;
            4: w = 18'h3FFFF;
            default: w = BITS'($urandom);
         endcase
         p[TOT-1-BITS*k -: BITS] = w;
      end
      return p;
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   endtask

   // Monitor: all port observations at the falling clock edge
   always @(negedge clk) begin
      cyc++;
      for (int g = 0; g < 2; g++) begin
         if (rst_n) begin
            if (cnv[g] && !cnv_p[g]) begin
               if (nrise[g] > 0)
                  check(cyc - t_rise[g] >= (g == 0 ? MINP0 : MINP1), "R3 strobe spacing",
                        64'(cyc - t_rise[g]), 64'(g == 0 ? MINP0 : MINP1));
               if (nfall[g] > 0)
                  check(cyc - t_fall[g] >= (g == 0 ? ACQ0 : ACQ1), "R4 acquisition low time",
                        64'(cyc - t_fall[g]), 64'(g == 0 ? ACQ0 : ACQ1));
               check(got[g] == NDEV * nrise[g], "R10 words drained before launch",
                     64'(got[g]), 64'(NDEV * nrise[g]));
               nrise[g]++;
               t_rise[g]    = cyc;
               sck_first[g] = 1'b1;
               falls[g]     = 0;
            end
            if (!cnv[g] && cnv_p[g]) begin
               if (g == 0) check(falls[g] == TOT, "R7 falling edges per burst", 64'(falls[g]), 64'(TOT));
               else        check(falls[g] == TOT + 1, "R6 falling edges with flag bit", 64'(falls[g]), 64'(TOT + 1));
               nfall[g]++;
               t_fall[g] = cyc;
            end
            if (sck[g] && !sck_p[g]) begin
               check(cnv[g], "R7 sck only while strobe high", 64'(cnv[g]), 64'd1);
               if (sck_first[g] && g == 0)
                  check(cyc - t_rise[g] >= CW0, "R5 readout after conversion wait",
                        64'(cyc - t_rise[g]), 64'(CW0));
               sck_first[g] = 1'b0;
            end
            if (!sck[g] && sck_p[g]) falls[g]++;
            if (stall_p[g])
               check(valid[g] && wdata[g] == data_p[g] && widx[g] == idx_p[g], "R9 stalled word held",
                     {valid[g], wdata[g], widx[g]}, {1'b1, data_p[g], idx_p[g]});
            if (valid[g] && ready_q[g]) begin
               check(wdata[g] == exp_word(held[g], got[g] % NDEV) && widx[g] == 2'(got[g] % NDEV),
                     "R8 word data and index",
                     {wdata[g], widx[g]}, {exp_word(held[g], got[g] % NDEV), 2'(got[g] % NDEV)});
               got[g]++;
            end
         end
         stall_p[g] = rst_n && valid[g] && !ready_q[g];
         data_p[g]  = wdata[g];
         idx_p[g]   = widx[g];
      end
      cnv_p = cnv;
      sck_p = sck;
   end

   // Random backpressure, updated just after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1 ready_q = {1'($urandom % 3 != 0), 1'($urandom % 4 != 0)};
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   task automatic run_dut(input int g);
      for (int it = 0; it < ITER; it++) begin
         data_q[g]  = pattern(it);
         start_q[g] = 1'b1;
         wait (got[g] >= NDEV * (it + 2));
      end
      start_q[g] = 1'b0;
   endtask

   initial begin
      int snap0, snap1;
      void'($urandom(32'd4242));
      for (int g = 0; g < 2; g++) begin
         got[g] = 0; nrise[g] = 0; nfall[g] = 0; falls[g] = 0;
         t_rise[g] = 0; t_fall[g] = 0; sck_first[g] = 0; stall_p[g] = 0;
         data_q[g] = pattern(9);
      end
      repeat (3) begin
         @(negedge clk);
         check(cnv == 2'b00 && sck == 2'b00 && valid == 2'b00, "R1 reset outputs low",
               64'({cnv, sck, valid}), 64'd0);
      end
      @(posedge clk); #1 rst_n = 1'b1;
      // Directed launch latency
      @(posedge clk); #1 start_q = 2'b11;
      @(posedge clk); #1 start_q = 2'b00;
      @(negedge clk);
      check(cnv == 2'b11, "R2 strobe one cycle after start", 64'(cnv), 64'd3);
      wait (got[0] >= NDEV && got[1] >= NDEV);
      fork
         run_dut(0);
         run_dut(1);
      join
      repeat (5) @(negedge clk);
      snap0 = nrise[0]; snap1 = nrise[1];
      repeat (600) @(negedge clk);
      check(nrise[0] == snap0 && nrise[1] == snap1 && cnv == 2'b00, "R2 no launch without start",
            64'(nrise[0] + nrise[1]), 64'(snap0 + snap1));
      check(got[0] == NDEV * (ITER + 1) && got[1] == NDEV * (ITER + 1), "R8 total words delivered",
            64'(got[0] + got[1]), 64'(2 * NDEV * (ITER + 1)));
      finish_run();
   end
endmodule